// File: doc/BRIEF.md
# Servoed Variable-Depth Receive Pipeline

This block sits in a receive data path and passes every data word through a short tapped delay line whose depth can change at run time. A read pointer picks the tap the output register samples, so the pointer value is the number of clock cycles the word spends in the block. At reset the pointer sits in the middle of the line, leaving room to grow or shrink the path in either direction.

A separate measurement circuit supplies a round-trip delay value with a valid strobe. The block compares each accepted measurement with a programmed target. If the path is too long the pointer drops by one; if it is too short the pointer rises by one. After each step the block waits a programmable number of cycles so that the new depth can be measured again before the next step is allowed. A two-bit status tells software whether the target is held, or whether the pointer has run out of range and the target itself must be raised or lowered.

Top module: `rtd_pipe_calibrator`

## Requirements
- R1: While reset is high and in the first cycle after it, `ptr` equals NUM_STAGES/2+1 (3 for five stages) and `status` is 2'b00.
- R2: `dout` equals the `din` word applied exactly `ptr` clock cycles earlier, for every pointer value from 1 to NUM_STAGES; at the centre setting this is NUM_STAGES/2+1 cycles.
- R3: An accepted strobe with `meas_rtd` greater than `target_rtd` and `ptr` above 1 lowers `ptr` by one on that clock edge and sets `status` to 2'b00.
- R4: An accepted strobe with `meas_rtd` less than `target_rtd` and `ptr` below NUM_STAGES raises `ptr` by one on that clock edge and sets `status` to 2'b00.
- R5: An accepted strobe with `meas_rtd` equal to `target_rtd` leaves `ptr` unchanged and sets `status` to 2'b11 (locked).
- R6: An accepted strobe with `meas_rtd` greater than `target_rtd` while `ptr` is 1 leaves `ptr` at 1 and sets `status` to 2'b01 (target must be raised).
- R7: An accepted strobe with `meas_rtd` less than `target_rtd` while `ptr` is NUM_STAGES leaves `ptr` there and sets `status` to 2'b10 (target must be lowered).
- R8: After a pointer step, strobes at the next `settle_cycles` clock edges are ignored; the strobe at the edge after that is accepted.
- R9: In a cycle where `target_rtd` differs from its value in the previous cycle, `status` becomes 2'b00 and any strobe in that cycle is ignored.
- R10: While `cal_en` is low, `ptr` holds its value, `status` is 2'b00 and strobes are ignored; when `cal_en` returns high, stepping resumes from the held pointer.
- R11: Across a pointer change the output word sequence repeats at most one word or skips at most one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_en | input | 1 | Calibration enable; low freezes the pointer |
| target_rtd | input | DELAY_W | Programmed target round-trip delay |
| meas_rtd | input | DELAY_W | Measured round-trip delay |
| meas_valid | input | 1 | One-cycle strobe marking a new measurement |
| settle_cycles | input | SETTLE_W | Clock edges to ignore strobes after a step |
| din | input | DATA_W | Receive data input |
| dout | output | DATA_W | Delayed receive data |
| ptr | output | PTR_W | Current tap selection, 1 to NUM_STAGES |
| status | output | 2 | 00 off/unmeasured, 01 raise target, 10 lower target, 11 locked |

## Verification
A pointer that lands on the wrong value shows at once as a changed latency of `dout` against `din`, visible one cycle after the bad step, and the bench compares that latency to the expected pointer at every setting from 1 to 5. A settle counter that runs too long or too short shows as a strobe wrongly taken or wrongly dropped within the settle window, which the bench probes at each of its edges. Status mis-encoding shows on the cycle after the deciding strobe, and a bad tap multiplexer shows as a word jump greater than two, tracked on every cycle.

// File: rtl/rtd_cal_pkg.sv
package rtd_cal_pkg;
  typedef enum logic [1:0] {
    CAL_OFF       = 2'b00,
    CAL_RAISE_TGT = 2'b01,
    CAL_LOWER_TGT = 2'b10,
    CAL_LOCKED    = 2'b11
  } cal_status_e;
endpackage

// File: rtl/rtd_tap_line.sv
module rtd_tap_line #(
  parameter int DATA_W     = 16,
  parameter int NUM_STAGES = 5,
  parameter int PTR_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  sel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NREG = NUM_STAGES - 1;

  // Shift registers without reset so they can map to shift-register primitives
  logic [DATA_W-1:0] stage_q [1:NREG];
  logic [DATA_W-1:0] picked;

  generate
    for (genvar k = 1; k <= NREG; k++) begin : g_stage
      if (k == 1) begin : g_first
        always_ff @(posedge clk) stage_q[k] <= din;
      end else begin : g_next
        always_ff @(posedge clk) stage_q[k] <= stage_q[k-1];
      end
    end
  endgenerate

  // sel = 1 takes din directly; sel = k+1 takes the k-th register
  always_comb begin
    picked = din;
    for (int k = 1; k <= NREG; k++) begin
      if (int'(sel) == k + 1) picked = stage_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= picked;
  end

  a_r2_sel_range: assert property (@(posedge clk) disable iff (rst)
    (int'(sel) >= 1) && (int'(sel) <= NUM_STAGES));
endmodule

// File: rtl/rtd_settle_timer.sv
module rtd_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  output logic                busy
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  a_r8_load_only_when_idle: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load);
endmodule

// File: rtl/rtd_step_servo.sv
module rtd_step_servo
  import rtd_cal_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int DELAY_W    = 16,
  parameter int PTR_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cal_en,
  input  logic [DELAY_W-1:0] target,
  input  logic [DELAY_W-1:0] meas,
  input  logic               meas_valid,
  input  logic               busy,
  output logic               step,
  output logic [PTR_W-1:0]   ptr_q,
  output cal_status_e        status_q
);
  localparam logic [PTR_W-1:0] PTR_MIN    = PTR_W'(1);
  localparam logic [PTR_W-1:0] PTR_MAX    = PTR_W'(NUM_STAGES);
  localparam logic [PTR_W-1:0] PTR_CENTRE = PTR_W'(NUM_STAGES / 2 + 1);

  logic [DELAY_W-1:0] target_q;
  logic               tgt_change;
  logic               accept;
  logic [PTR_W-1:0]   ptr_d;
  cal_status_e        status_d;

  always_ff @(posedge clk) begin
    if (rst) target_q <= '0;
    else     target_q <= target;
  end

  assign tgt_change = (target != target_q);
  assign accept     = cal_en && meas_valid && !busy && !tgt_change;

  always_comb begin
    ptr_d    = ptr_q;
    status_d = status_q;
    step     = 1'b0;
    if (!cal_en || tgt_change) begin
      status_d = CAL_OFF;
    end else if (accept) begin
      if (meas > target) begin
        if (ptr_q > PTR_MIN) begin
          ptr_d    = ptr_q - 1'b1;
          step     = 1'b1;
          status_d = CAL_OFF;
        end else begin
          status_d = CAL_RAISE_TGT;
        end
      end else if (meas < target) begin
        if (ptr_q < PTR_MAX) begin
          ptr_d    = ptr_q + 1'b1;
          step     = 1'b1;
          status_d = CAL_OFF;
        end else begin
          status_d = CAL_LOWER_TGT;
        end
      end else begin
        status_d = CAL_LOCKED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= PTR_CENTRE;
      status_q <= CAL_OFF;
    end else begin
      ptr_q    <= ptr_d;
      status_q <= status_d;
    end
  end

  // R3 / R4: the pointer never moves more than one tap per edge
  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ptr_q == $past(ptr_q)) || (ptr_q == $past(ptr_q) + 1'b1) ||
              (ptr_q == $past(ptr_q) - 1'b1)));
  a_r8_settle_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ptr_q));
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    !cal_en |=> ($stable(ptr_q) && (status_q == CAL_OFF)));
  a_r6_raise_at_min: assert property (@(posedge clk) disable iff (rst)
    (status_q == CAL_RAISE_TGT) |-> (ptr_q == PTR_MIN));
  a_r7_lower_at_max: assert property (@(posedge clk) disable iff (rst)
    (status_q == CAL_LOWER_TGT) |-> (ptr_q == PTR_MAX));
  a_r9_target_clear: assert property (@(posedge clk) disable iff (rst)
    tgt_change |=> (status_q == CAL_OFF) && $stable(ptr_q));
endmodule

// File: rtl/rtd_pipe_calibrator.sv
module rtd_pipe_calibrator
  import rtd_cal_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_STAGES = 5,
  parameter int DELAY_W    = 16,
  parameter int SETTLE_W   = 8,
  parameter int PTR_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cal_en,
  input  logic [DELAY_W-1:0]  target_rtd,
  input  logic [DELAY_W-1:0]  meas_rtd,
  input  logic                meas_valid,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   dout,
  output logic [PTR_W-1:0]    ptr,
  output logic [1:0]          status
);
  logic        busy;
  logic        step;
  cal_status_e status_e;

  rtd_step_servo #(
    .NUM_STAGES(NUM_STAGES), .DELAY_W(DELAY_W), .PTR_W(PTR_W)
  ) u_servo (
    .clk(clk), .rst(rst), .cal_en(cal_en), .target(target_rtd),
    .meas(meas_rtd), .meas_valid(meas_valid), .busy(busy),
    .step(step), .ptr_q(ptr), .status_q(status_e)
  );

  rtd_settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk(clk), .rst(rst), .load(step), .load_val(settle_cycles), .busy(busy)
  );

  rtd_tap_line #(
    .DATA_W(DATA_W), .NUM_STAGES(NUM_STAGES), .PTR_W(PTR_W)
  ) u_taps (
    .clk(clk), .rst(rst), .sel(ptr), .din(din), .dout(dout)
  );

  assign status = status_e;

  a_r5_lock_holds_ptr: assert property (@(posedge clk) disable iff (rst)
    (status_e == CAL_LOCKED) |-> !busy);
endmodule

// File: tb/rtd_pipe_calibrator_test.sv
module rtd_pipe_calibrator_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cal_en = 1'b0;
  logic [15:0] target_rtd = 16'd60;
  logic [15:0] meas_rtd = '0;
  logic        meas_valid = 1'b0;
  logic [7:0]  settle_cycles = 8'd3;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [2:0]  ptr;
  logic [1:0]  status;

  int checks = 0, fails = 0, glitches = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [15:0] prev_dout = '0;

  always #5 clk = ~clk;

  rtd_pipe_calibrator uut (
    .clk(clk), .rst(rst), .cal_en(cal_en), .target_rtd(target_rtd),
    .meas_rtd(meas_rtd), .meas_valid(meas_valid), .settle_cycles(settle_cycles),
    .din(din), .dout(dout), .ptr(ptr), .status(status)
  );

  // incrementing data word, changed away from the active edge
  always @(negedge clk) din <= din + 16'd1;

  // R11 monitor: successive output words differ by 0, 1 or 2
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      if (16'(dout - prev_dout) > 16'd2) glitches++;
    end
    prev_dout = dout;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  // called at negedge+2; the strobe is captured by the next posedge
  task automatic strobe(input int m);
    meas_rtd = 16'(m);
    meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
    #2;
  endtask

  task automatic lat(input string tag, input int p);
    chk(tag, int'(16'(din - dout)), p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    chk("R1 reset ptr", ptr, 3);
    chk("R1 reset status", status, 0);
    idle(8);
    lat("R2 latency at centre", 3);
    mon_on = 1'b1;

    cal_en = 1'b1;
    idle(2);
    strobe(61);
    chk("R3 step down ptr", ptr, 2);
    chk("R3 status after step", status, 0);
    idle(6);
    lat("R2 latency ptr2", 2);
    strobe(60);
    chk("R5 locked status", status, 3);
    chk("R5 ptr unchanged", ptr, 2);

    // target change with a matching strobe in the same cycle
    target_rtd = 16'd62;
    strobe(62);
    chk("R9 status cleared", status, 0);
    chk("R9 ptr unchanged", ptr, 2);
    strobe(61);
    chk("R4 step up ptr", ptr, 3);
    for (int p = 4; p <= 5; p++) begin
      idle(6);
      strobe(61);
      chk("R4 sweep up ptr", ptr, p);
      idle(6);
      lat("R2 latency sweep up", p);
    end
    strobe(61);
    chk("R7 saturate ptr", ptr, 5);
    chk("R7 status lower target", status, 2);

    // settle window
    target_rtd = 16'd60;
    idle(2);
    strobe(61);
    chk("R8 first step", ptr, 4);
    for (int i = 0; i < 3; i++) begin
      strobe(61);
      chk("R8 strobe ignored in settle", ptr, 4);
    end
    strobe(61);
    chk("R8 strobe accepted after settle", ptr, 3);
    for (int p = 2; p >= 1; p--) begin
      idle(6);
      strobe(61);
      chk("R3 sweep down ptr", ptr, p);
      idle(6);
      lat("R2 latency sweep down", p);
    end
    strobe(61);
    chk("R6 saturate ptr", ptr, 1);
    chk("R6 status raise target", status, 1);
    strobe(60);
    chk("R5 locked at min", status, 3);

    // disable freezes
    cal_en = 1'b0;
    strobe(59);
    chk("R10 ptr frozen", ptr, 1);
    chk("R10 status off", status, 0);
    idle(3);
    chk("R10 ptr still frozen", ptr, 1);
    cal_en = 1'b1;
    strobe(59);
    chk("R10 resumes stepping", ptr, 2);
    idle(6);

    chk("R11 no output glitch", glitches, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule